// File: doc/BRIEF.md
# Sense-Reversing Hardware Barrier

This block synchronises a fixed group of participants at a barrier. Each participant signals arrival with a one-cycle pulse on its arrive line. The unit keeps a sense bit for every participant, a shared arrival counter and a single global release bit. An accepted arrival inverts the sense bit of that participant. The unit adds the number of accepted arrivals in a cycle to the counter as one indivisible update.

When the counter reaches the participant count, the unit clears the counter and sets the release bit equal to the new sense of the arrivers. Every participant whose sense matches the release bit sees its done line high. The release bit is never forced back to a fixed value. For that reason, a new episode can start in the cycle right after the barrier opens, and no participant can be left waiting on a stale flag. A participant that pulses arrive while its done line is low has already arrived in the current episode. That pulse is ignored and reported on the participant's error line.

Top module: `sense_barrier`

## Requirements
- R1: After reset, the counter and the release bit are 0, every sense bit is 0, every done_o bit is 1 and every err_o bit is 0.
- R2: An arrive pulse from a participant whose done_o is 1 is accepted and inverts that participant's sense bit. If that arrival does not complete the episode, the participant's done_o reads 0 from the next cycle on.
- R3: The counter advances by the number of arrivals accepted in a cycle and never holds a value equal to or above N_PART. The barrier opens only when exactly N_PART distinct participants have arrived in the episode.
- R4: When the count reaches N_PART, the counter returns to 0 and the release bit takes the new sense of the arrivers. From the next cycle, all done_o bits read 1.
- R5: Arrivals from several participants in the same cycle are all counted. If together they complete the episode, the release bit changes exactly once.
- R6: An arrive pulse from a participant whose done_o is 0 has no effect on the counter or on that participant's sense bit. The matching err_o bit goes high for exactly the next cycle.
- R7: A new episode may begin in the cycle right after the barrier opens, and it behaves the same as the first episode.
- R8: done_o[i] is 1 exactly while the release bit equals the sense bit of participant i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arrive_i | input | N_PART | One-cycle arrival pulse per participant |
| done_o | output | N_PART | Per participant: 1 while the release bit equals its sense |
| err_o | output | N_PART | One-cycle flag for an arrival repeated within an episode |

## Verification
Every result is registered once. A done_o or err_o change caused by an arrive pulse sampled at a clock edge appears just after that edge, which is one cycle after the pulse. The bench drives arrive_i on the falling edge and holds it for one full cycle. It samples done_o and err_o on the following falling edge, half a cycle after the edge that updates them. The one-cycle width of the error flag is checked on the falling edge after that. The counter value is seen only through the cycle in which all done bits rise, so each scenario counts how many distinct arrivals must come before the barrier opens.

// File: rtl/sense_barrier_pkg.sv
package sense_barrier_pkg;
  function automatic int unsigned cnt_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/barrier_slot.sv
module barrier_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arrive_i,
  input  logic release_i,
  output logic accept_o,
  output logic done_o,
  output logic err_o
);
  logic sense_q;
  logic err_q;

  assign done_o   = (sense_q == release_i);
  assign accept_o = arrive_i & done_o;
  assign err_o    = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (accept_o) sense_q <= ~sense_q;
      err_q <= arrive_i & ~done_o;
    end
  end

  // R6: a repeated arrival leaves the sense untouched
  a_r6_repeat_keeps_sense: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arrive_i && !done_o) |=> $stable(sense_q));
endmodule

// File: rtl/barrier_count.sv
module barrier_count #(
  parameter int unsigned N_PART = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PART-1:0] accept_i,
  output logic              release_o,
  output logic              open_o
);
  import sense_barrier_pkg::*;
  localparam int unsigned CW = cnt_bits(N_PART);

  logic [CW-1:0] count_q;
  logic [CW-1:0] n_arr;
  logic [CW-1:0] sum;
  logic          release_q;

  always_comb begin
    n_arr = '0;
    for (int i = 0; i < N_PART; i++) n_arr = n_arr + CW'(accept_i[i]);
  end

  assign sum       = count_q + n_arr;
  assign open_o    = (sum == CW'(N_PART));
  assign release_o = release_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q   <= '0;
      release_q <= 1'b0;
    end else begin
      count_q <= open_o ? '0 : sum;
      if (open_o) release_q <= ~release_q;
    end
  end

  // R3: counter stays below the participant count
  a_r3_count_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q < CW'(N_PART));
endmodule

// File: rtl/sense_barrier.sv
module sense_barrier #(
  parameter int unsigned N_PART = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PART-1:0] arrive_i,
  output logic [N_PART-1:0] done_o,
  output logic [N_PART-1:0] err_o
);
  logic [N_PART-1:0] accept;
  logic              release_bit;
  logic              open;

  barrier_count #(.N_PART(N_PART)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .release_o (release_bit),
    .open_o    (open)
  );

  for (genvar g = 0; g < N_PART; g++) begin : g_slot
    barrier_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .arrive_i  (arrive_i[g]),
      .release_i (release_bit),
      .accept_o  (accept[g]),
      .done_o    (done_o[g]),
      .err_o     (err_o[g])
    );

    // R2: an arrival that does not open the barrier makes the participant wait
    a_r2_arrival_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (arrive_i[g] && done_o[g] && !open) |=> !done_o[g]);
  end

  // R4: opening the barrier releases every participant
  a_r4_open_all_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open |=> (&done_o));
endmodule

// File: tb/sense_barrier_bench.sv
`timescale 1ns/1ps
module sense_barrier_bench;
  localparam int unsigned N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] arrive = '0;
  logic [N-1:0] done;
  logic [N-1:0] err;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sense_barrier #(.N_PART(N)) u_sense_barrier (
    .clk_i(clk), .rst_ni(rst_n), .arrive_i(arrive), .done_o(done), .err_o(err)
  );

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive for one cycle; outputs sampled at the next falling edge
  task automatic pulse(logic [N-1:0] m);
    arrive = m;
    @(negedge clk);
    arrive = '0;
  endtask

  task automatic t_reset();
    chk("R1 done", done, 4'b1111);
    chk("R1 err", err, 4'b0000);
    chk("R8 idle", done, 4'b1111);
  endtask

  task automatic t_sequential();
    pulse(4'b0001); chk("R2 p0", done, 4'b1110);
    pulse(4'b0010); chk("R2 p1", done, 4'b1100);
    pulse(4'b0100); chk("R3 p2 no open", done, 4'b1000);
    pulse(4'b1000); chk("R4 open", done, 4'b1111);
    chk("R4 no err", err, 4'b0000);
  endtask

  task automatic t_repeat();
    pulse(4'b0001); chk("R2 first", done, 4'b1110);
    pulse(4'b0001); chk("R6 ignored", done, 4'b1110);
    chk("R6 err", err, 4'b0001);
    @(negedge clk); chk("R6 err one cycle", err, 4'b0000);
    pulse(4'b0011); chk("R6 mixed", done, 4'b1100);
    chk("R6 mixed err", err, 4'b0001);
    pulse(4'b0100); chk("R3 repeats uncounted", done, 4'b1000);
    pulse(4'b1000); chk("R4 open after repeats", done, 4'b1111);
  endtask

  task automatic t_simultaneous();
    pulse(4'b0011); chk("R5 pair", done, 4'b1100);
    pulse(4'b1100); chk("R5 pair open", done, 4'b1111);
    pulse(4'b1111); chk("R5 all at once", done, 4'b1111);
    chk("R5 no err", err, 4'b0000);
    pulse(4'b0001); chk("R5 single toggle", done, 4'b1110);
    pulse(4'b1110); chk("R5 three close", done, 4'b1111);
  endtask

  task automatic t_back_to_back();
    pulse(4'b1111); chk("R7 ep1", done, 4'b1111);
    pulse(4'b0110); chk("R7 ep2 start", done, 4'b1001);
    pulse(4'b1001); chk("R7 ep2 open", done, 4'b1111);
    pulse(4'b1000); chk("R7 ep3 start", done, 4'b0111);
    pulse(4'b0111); chk("R7 ep3 open", done, 4'b1111);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sequential();
    t_repeat();
    t_simultaneous();
    t_back_to_back();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule